// File: doc/BRIEF.md
# Four-Lane Multiplier Group with Operand Shift Chain and Result Feedback

This block is a group of four signed 18x18 multipliers. Each lane registers its A and B operands and then registers the 36-bit product one cycle later. The A operand register of each lane is built, through an elaboration parameter, either to load the lane's own parallel input or to take the value held in the A register of the lane above. The first lane, when built for chaining, takes a dedicated cascade input. The last lane's A register drives a cascade output, so two groups wired output-to-input form one eight-tap delay line. This lets a FIR filter keep its sample history inside the multiplier group rather than in general logic.

The first lane can also be built so that its B register takes the upper 18 bits of its own registered product. This gives the feedback that a recursive filter needs. A seed strobe loads the lane's parallel B input in place of the feedback, which sets the starting value of the recursion. One enable gates every register in the group, and a synchronous reset clears all of them.

Top module: `mulgrp_top`

## Requirements
- R1: A lane whose bit in parameter SHIFT_SEL is 0 loads its A register from its own slice of `a_in` (lane i occupies bits [i*18 +: 18]) on every enabled clock edge.
- R2: A lane whose SHIFT_SEL bit is 1 loads its A register from the A register of lane i-1 on every enabled edge. For lane 0 the source is `cas_in` instead. The parallel A input of a chained lane has no effect.
- R3: `cas_out` always equals the A register of the last lane. When two fully chained groups are joined, the eighth tap holds the `cas_in` value from eight enabled edges earlier.
- R4: Every B register loads its own slice of `b_in` on each enabled edge. The only exception is lane 0 of a group built with LOOPBACK=1. B values never pass between lanes.
- R5: In a group built with LOOPBACK=1, lane 0's B register loads bits [35:18] of lane 0's product register on each enabled edge while `fb_load` is 0. While `fb_load` is 1, it loads `b_in` lane 0 instead.
- R6: While `en` is 0, no A, B or product register changes. This holds for the shift chain and for the feedback loop.
- R7: A clock edge with `rst` at 1 clears every A, B and product register to zero.
- R8: Each product register, lane i at `prod_out[i*36 +: 36]`, loads the signed two's-complement product of that lane's A and B registers. The output therefore shows operands presented on edge n after edge n+1.
- R9: In a group built with LOOPBACK=0, `fb_load` has no effect and lane 0's B register follows `b_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable shared by all registers |
| fb_load | input | 1 | Seed strobe: lane 0 B loads `b_in` instead of the feedback value |
| a_in | input | 72 | Parallel A operands, 18 bits per lane |
| b_in | input | 72 | Parallel B operands, 18 bits per lane |
| cas_in | input | 18 | Shift-chain input from the group above |
| cas_out | output | 18 | Shift-chain output to the group below (last lane's A register) |
| prod_out | output | 144 | Registered signed products, 36 bits per lane |

## Verification
The bench joins two fully chained groups into an eight-tap line and checks every tap's product against a software delay line. Taps offset by one, or a cascade taken from the wrong lane, therefore show up as mismatched products on all downstream lanes. A third group mixes parallel and chained lanes and runs a seeded recursion with negative and positive coefficients. Feeding back the wrong bits, or feeding back in the same cycle instead of through the product register, makes the decay sequence diverge from the reference after the first step. Bursts with the enable low, applied in the middle of shifting and in the middle of recursion, catch a chain or feedback loop that keeps moving. A reset in the middle of a run catches a register left out of the clear. Operands at -131072, 131071, -1 and 0 exercise the sign extension of the full-width product.

// File: rtl/mulgrp_pkg.sv
package mulgrp_pkg;

  localparam int OPND_W_DEF = 18;

  // Full signed product of two sign-extended operands.
  function automatic longint mul_signed(input longint a, input longint b);
    return a * b;
  endfunction

  // Arithmetic right shift used to take the upper part of a product.
  function automatic longint upper_part(input longint p, input int drop);
    return p >>> drop;
  endfunction

endpackage

// File: rtl/mulgrp_a_chain.sv
module mulgrp_a_chain #(
  parameter int LANES = 4,
  parameter int AW = 18,
  parameter logic [LANES-1:0] SHIFT_SEL = {LANES{1'b1}}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [LANES*AW-1:0]   a_par,
  input  logic [AW-1:0]         cas_in,
  output logic [LANES*AW-1:0]   a_q,
  output logic [AW-1:0]         cas_out
);

  logic [AW-1:0] a_r   [LANES];
  logic [AW-1:0] a_src [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (SHIFT_SEL[i]) begin : g_chain
      if (i == 0) begin : g_head
        assign a_src[i] = cas_in;
      end else begin : g_link
        assign a_src[i] = a_r[i-1];
      end
    end else begin : g_par
      assign a_src[i] = a_par[i*AW +: AW];
    end

    always_ff @(posedge clk) begin
      if (rst)     a_r[i] <= '0;
      else if (en) a_r[i] <= a_src[i];
    end

    assign a_q[i*AW +: AW] = a_r[i];

    // R6: a disabled edge leaves the tap untouched
    p_a_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(a_r[i]));

    if (SHIFT_SEL[i] && i > 0) begin : g_chk_link
      // R2: tap i takes the old value of tap i-1
      p_chain_step_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> a_r[i] == $past(a_r[i-1]));
    end else if (SHIFT_SEL[i]) begin : g_chk_head
      // R2: chained head lane takes the cascade input
      p_chain_head_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> a_r[i] == $past(cas_in));
    end else begin : g_chk_par
      // R1: parallel lane takes its own input slice
      p_par_load_r1: assert property (@(posedge clk) disable iff (rst)
        en |=> a_r[i] == $past(a_par[i*AW +: AW]));
    end
  end

  assign cas_out = a_r[LANES-1];

endmodule

// File: rtl/mulgrp_b_sel.sv
module mulgrp_b_sel #(
  parameter int LANES = 4,
  parameter int BW = 18,
  parameter bit LOOPBACK = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  fb_load,
  input  logic [LANES*BW-1:0]   b_par,
  input  logic [BW-1:0]         fb_hi,
  output logic [LANES*BW-1:0]   b_q
);

  logic [BW-1:0] b_r   [LANES];
  logic [BW-1:0] b_src [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (LOOPBACK && i == 0) begin : g_fb
      assign b_src[i] = fb_load ? b_par[i*BW +: BW] : fb_hi;
      // R5: recursion path takes the fed-back upper product bits
      p_fb_take_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !fb_load) |=> b_r[i] == $past(fb_hi));
      // R5: seed strobe overrides the feedback
      p_fb_seed_r5: assert property (@(posedge clk) disable iff (rst)
        (en && fb_load) |=> b_r[i] == $past(b_par[i*BW +: BW]));
    end else begin : g_own
      assign b_src[i] = b_par[i*BW +: BW];
      // R4: plain B lanes follow their own input only
      p_b_own_r4: assert property (@(posedge clk) disable iff (rst)
        en |=> b_r[i] == $past(b_par[i*BW +: BW]));
    end

    always_ff @(posedge clk) begin
      if (rst)     b_r[i] <= '0;
      else if (en) b_r[i] <= b_src[i];
    end

    assign b_q[i*BW +: BW] = b_r[i];

    // R6: B registers are frozen while disabled
    p_b_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(b_r[i]));
  end

endmodule

// File: rtl/mulgrp_lane_mul.sv
module mulgrp_lane_mul
  import mulgrp_pkg::*;
#(
  parameter int AW = 18,
  parameter int BW = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [AW-1:0]    a,
  input  logic signed [BW-1:0]    b,
  output logic signed [AW+BW-1:0] p
);

  localparam int PW = AW + BW;

  logic signed [PW-1:0] prod_next;

  always_comb prod_next = PW'(mul_signed(longint'(a), longint'(b)));

  always_ff @(posedge clk) begin
    if (rst)     p <= '0;
    else if (en) p <= prod_next;
  end

  // R8: product lags its operand registers by one enabled edge
  p_prod_lag_r8: assert property (@(posedge clk) disable iff (rst)
    en |=> p == PW'(mul_signed(longint'($past(a)), longint'($past(b)))));

  // R6: product register frozen while disabled
  p_prod_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(p));

endmodule

// File: rtl/mulgrp_top.sv
module mulgrp_top
  import mulgrp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW = OPND_W_DEF,
  parameter int BW = OPND_W_DEF,
  parameter logic [LANES-1:0] SHIFT_SEL = {{(LANES-1){1'b1}}, 1'b0},
  parameter bit LOOPBACK = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        fb_load,
  input  logic [LANES*AW-1:0]         a_in,
  input  logic [LANES*BW-1:0]         b_in,
  input  logic [AW-1:0]               cas_in,
  output logic [AW-1:0]               cas_out,
  output logic [LANES*(AW+BW)-1:0]    prod_out
);

  localparam int PW = AW + BW;

  logic [LANES*AW-1:0] a_q;
  logic [LANES*BW-1:0] b_q;
  logic [BW-1:0]       fb_hi;
  logic signed [PW-1:0] lane0_p;

  mulgrp_a_chain #(
    .LANES(LANES), .AW(AW), .SHIFT_SEL(SHIFT_SEL)
  ) i_a_chain (
    .clk(clk), .rst(rst), .en(en),
    .a_par(a_in), .cas_in(cas_in),
    .a_q(a_q), .cas_out(cas_out)
  );

  mulgrp_b_sel #(
    .LANES(LANES), .BW(BW), .LOOPBACK(LOOPBACK)
  ) i_b_sel (
    .clk(clk), .rst(rst), .en(en), .fb_load(fb_load),
    .b_par(b_in), .fb_hi(fb_hi), .b_q(b_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    mulgrp_lane_mul #(.AW(AW), .BW(BW)) i_mul (
      .clk(clk), .rst(rst), .en(en),
      .a(a_q[i*AW +: AW]),
      .b(b_q[i*BW +: BW]),
      .p(prod_out[i*PW +: PW])
    );
  end

  assign lane0_p = prod_out[PW-1:0];
  assign fb_hi   = BW'(upper_part(longint'(lane0_p), PW - BW));

  // R3: cascade output moves with the last tap and holds when disabled
  p_cas_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cas_out));

endmodule

// File: tb/test_mulgrp_top.sv
module test_mulgrp_top;
  localparam int CLK_P = 10;
  localparam int LN = 4;
  localparam int W = 18;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rst, en, fbl;
  logic [LN*W-1:0] a01, b01, a2, b2;
  logic [W-1:0] xin, c2;
  logic [W-1:0] co0, co1, co2;
  logic [LN*PW-1:0] p0, p1, p2;

  int nvec = 0;
  int nfail = 0;
  string ph = "";

  longint tap [8];
  longint bm  [8];
  longint pm  [8];
  longint aq2 [4];
  longint bq2 [4];
  longint pm2 [4];

  always #(CLK_P/2) clk = ~clk;

  mulgrp_top #(.SHIFT_SEL(4'b1111), .LOOPBACK(1'b0)) i_mulgrp_top (
    .clk(clk), .rst(rst), .en(en), .fb_load(fbl), .a_in(a01), .b_in(b01),
    .cas_in(xin), .cas_out(co0), .prod_out(p0));

  mulgrp_top #(.SHIFT_SEL(4'b1111), .LOOPBACK(1'b0)) i_mulgrp_top_tail (
    .clk(clk), .rst(rst), .en(en), .fb_load(fbl), .a_in(a01), .b_in(b01),
    .cas_in(co0), .cas_out(co1), .prod_out(p1));

  mulgrp_top #(.SHIFT_SEL(4'b1010), .LOOPBACK(1'b1)) i_mulgrp_top_fb (
    .clk(clk), .rst(rst), .en(en), .fb_load(fbl), .a_in(a2), .b_in(b2),
    .cas_in(c2), .cas_out(co2), .prod_out(p2));

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint px(input logic [PW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [W-1:0] pat(input int n, input int lane);
    logic [W-1:0] corner [5];
    corner[0] = 18'h20000; corner[1] = 18'h1FFFF; corner[2] = 18'h3FFFF;
    corner[3] = 18'h00000; corner[4] = 18'h00001;
    if ((n + lane) % 3 == 0) return corner[(n + 2*lane) % 5];
    return W'($urandom);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    longint nb0, old0, old2;
    if (rst) begin
      for (int k = 0; k < 8; k++) begin tap[k] = 0; bm[k] = 0; pm[k] = 0; end
      for (int k = 0; k < 4; k++) begin aq2[k] = 0; bq2[k] = 0; pm2[k] = 0; end
    end else if (en) begin
      nb0 = fbl ? sx(b2[W-1:0]) : ((pm2[0] >>> 18) & 64'h3FFFF);
      if (nb0 >= 131072) nb0 = nb0 - 262144;
      for (int k = 0; k < 8; k++) pm[k] = tap[k] * bm[k];
      for (int k = 0; k < 4; k++) pm2[k] = aq2[k] * bq2[k];
      for (int k = 7; k > 0; k--) tap[k] = tap[k-1];
      tap[0] = sx(xin);
      for (int k = 0; k < 8; k++) bm[k] = sx(b01[(k%4)*W +: W]);
      old0 = aq2[0]; old2 = aq2[2];
      aq2[0] = sx(a2[0 +: W]);
      aq2[1] = old0;
      aq2[2] = sx(a2[2*W +: W]);
      aq2[3] = old2;
      bq2[0] = nb0;
      for (int k = 1; k < 4; k++) bq2[k] = sx(b2[k*W +: W]);
    end
  endtask

  task automatic compare();
    string t;
    for (int k = 0; k < 8; k++) begin
      t = (ph != "") ? ph : ((k == 0 && fbl) ? "R9" : "R2");
      if (k < 4) chk(t, px(p0[k*PW +: PW]), pm[k]);
      else       chk(t, px(p1[(k-4)*PW +: PW]), pm[k]);
    end
    chk((ph != "") ? ph : "R3", sx(co1), tap[7]);
    chk((ph != "") ? ph : "R3", sx(co0), tap[3]);
    chk((ph != "") ? ph : "R5", px(p2[0 +: PW]), pm2[0]);
    chk((ph != "") ? ph : "R8", px(p2[PW +: PW]), pm2[1]);
    chk((ph != "") ? ph : "R1", px(p2[2*PW +: PW]), pm2[2]);
    chk((ph != "") ? ph : "R4", px(p2[3*PW +: PW]), pm2[3]);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic drive_rand(input int n);
    xin = pat(n, 7);
    c2  = pat(n, 9);
    for (int k = 0; k < LN; k++) begin
      a01[k*W +: W] = pat(n, k + 10);
      b01[k*W +: W] = pat(n, k);
      a2[k*W +: W]  = pat(n, k + 4);
      b2[k*W +: W]  = pat(n, k + 20);
    end
  endtask

  task automatic run_loop(input logic [W-1:0] coef, input logic [W-1:0] seed, input int len);
    a2[0 +: W] = coef;
    b2[0 +: W] = seed;
    fbl = 1'b1;
    step();
    fbl = 1'b0;
    for (int n = 0; n < len; n++) begin
      b2[0 +: W] = W'($urandom);  // ignored while the loop runs (R5)
      if (n == len/2) begin
        en = 1'b0; ph = "R6";
        step(); step();
        en = 1'b1; ph = "";
      end
      step();
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; fbl = 1'b0;
    a01 = '1; b01 = '1; a2 = '1; b2 = '1; xin = '1; c2 = '1;
    ph = "R7";
    step(); step();
    rst = 1'b0;
    ph = "";

    // chain sweep with corner operands
    en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      drive_rand(n);
      fbl = (n % 11 == 5);
      step();
    end

    // enable low bursts while inputs keep moving
    for (int n = 0; n < 60; n++) begin
      drive_rand(n + 1000);
      en = (n % 4 != 1) && (n % 4 != 2);
      ph = en ? "" : "R6";
      step();
    end
    en = 1'b1; ph = "";
    fbl = 1'b0;

    // recursion: negative coefficient halves and flips the sign
    run_loop(18'h20000, 18'd100000, 40);
    // positive coefficient 0.375 decay
    run_loop(18'h18000, 18'h2_0001, 30);
    // full-scale positive coefficient, negative seed
    run_loop(18'h1FFFF, 18'h3_0000, 30);

    // mid-run reset
    drive_rand(77);
    rst = 1'b1; ph = "R7";
    step();
    rst = 1'b0; ph = "";
    for (int n = 0; n < 40; n++) begin
      drive_rand(n + 2000);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule